// File: doc/BRIEF.md
# Flash Program/Erase Bit-7 Status Poller

This block sits between a flash array's read path and the host read port. While the embedded program or erase engine is working, it replaces bit 7 of the word returned on a read with a progress flag. The host polls this flag until it shows the final value. Outside an active operation, array data goes through untouched.

A command strobe marks the edge that completes a command sequence. It carries the operation kind, the target address, bit 7 of the datum being programmed and whether the target is protected. The flag is only replaced when the read address qualifies:

- For a program, the address must equal the latched target address. In a buffered program, the target address is the last word of the buffer.
- For an erase, the address must lie in a selected sector that is not protected.

For a protected target, the block runs its own countdown and then returns to read mode. Erase suspend and programming during suspend are tracked as states of their own.

Reads use a valid/ready request and a valid/ready response.

- The request carries the read address, the sector flags for that address and the array word.
- A request is accepted when `rd_req_ready_o` is high, which happens when no response is pending or the pending one is taken in the same cycle.
- The response register holds its data, without change, while `rsp_ready_i` is low.

Top module: `dq7_poll_unit`

## Requirements
- R1: With no operation active, an accepted read returns `array_data_i` unchanged, including bit 7.
- R2: During a program, a read whose address equals the latched program address returns bit 7 as the inverse of `op_d7_i`, with all other bits from the array. Reads at any other address return array data unchanged.
- R3: When `busy_i` is low during a program or an unsuspended erase, the block returns to read mode on the next edge. Reads accepted after that edge follow R1.
- R4: During an erase (`op_kind_i`=1), reads in a selected (`rd_in_sel_i`=1), unprotected (`rd_sec_prot_i`=0) sector return bit 7 = 0. Reads in a protected or an unselected sector return array data.
- R5: When `suspend_i` is high during an erase, reads in a selected unprotected sector return bit 7 = 1. Lowering `suspend_i` resumes the erase, and bit 7 = 0 returns.
- R6: A program command (`op_kind_i`=0) issued while suspended uses the R2 inverse rule at its address, and other selected unprotected addresses still read 1. When `busy_i` falls, the block returns to suspend.
- R7: A program command with `op_prot_i`=1 shows the R2 status for `PROG_ABORT_CYC` cycles regardless of `busy_i`, then returns to read mode.
- R8: An erase command with `op_prot_i`=1 makes reads in selected sectors return bit 7 = 0 for exactly `CLK_MHZ*ERASE_ABORT_US` cycles after the command edge, then returns to read mode.
- R9: A command strobe while a program or erase is running is ignored.
- R10: A response appears one edge after its request is accepted. It stays valid with stable data while `rsp_ready_i` is low, and no new request is accepted while it is stalled.
- R11: A read accepted on the same edge as the command strobe still returns plain array data. Status starts with reads accepted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | One-cycle strobe marking the final write pulse of a command sequence |
| op_kind_i | input | 1 | 0 = program, 1 = erase |
| op_prot_i | input | 1 | Program target protected, or every erase-selected sector protected |
| op_addr_i | input | ADDR_W | Program address (last buffered word for buffer programming) |
| op_d7_i | input | 1 | Bit 7 of the datum being programmed |
| busy_i | input | 1 | Embedded engine running |
| suspend_i | input | 1 | Erase suspend request/level |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_ready_o | output | 1 | Read request accepted this cycle when high |
| rd_addr_i | input | ADDR_W | Read address |
| rd_in_sel_i | input | 1 | Read address lies in a sector selected for erase |
| rd_sec_prot_i | input | 1 | Read address lies in a protected sector |
| array_data_i | input | DATA_W | Array word at the read address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_data_o | output | DATA_W | Read word with bit 7 possibly replaced by status |

## Verification
Each read response is due exactly one edge after the edge that accepts its request. The status a response shows depends on the state in force before that edge, so a command on the same edge has no effect yet. The protected-erase window is checked at its two boundary edges: a read accepted on edge `CLK_MHZ*ERASE_ABORT_US` after the command must show 0, and the read on the edge after it must show array data. All stimulus is driven on the falling edge. The scoreboard takes each expected word in request order and compares it one time unit after a falling edge on which the response is being handed over, so every comparison meets the response in the cycle it is due.

// File: rtl/dq7_poll_pkg.sv
package dq7_poll_pkg;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4,
    ST_PPROT = 3'd5,
    ST_EPROT = 3'd6
  } poll_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

endpackage

// File: rtl/dq7_poll_seq.sv
module dq7_poll_seq
  import dq7_poll_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int PROG_ABORT_CYC  = 16,
  parameter int ERASE_ABORT_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_i,
  input  op_kind_e          op_kind_i,
  input  logic              op_prot_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              op_d7_i,
  input  logic              busy_i,
  input  logic              suspend_i,
  output poll_state_e       st_o,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              lat_d7_o
);

  localparam int MAX_CYC = (ERASE_ABORT_CYC > PROG_ABORT_CYC) ? ERASE_ABORT_CYC : PROG_ABORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_ABORT_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_ABORT_CYC - 1);

  poll_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_d7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_READ;
      cnt      <= '0;
      lat_addr <= '0;
      lat_d7   <= 1'b0;
    end else begin
      unique case (st)
        ST_READ: begin
          if (cmd_i) begin
            lat_addr <= op_addr_i;
            lat_d7   <= op_d7_i;
            if (op_kind_i == OP_ERASE) begin
              if (op_prot_i) begin
                st  <= ST_EPROT;
                cnt <= ERASE_LOAD;
              end else begin
                st <= ST_ERASE;
              end
            end else begin
              if (op_prot_i) begin
                st  <= ST_PPROT;
                cnt <= PROG_LOAD;
              end else begin
                st <= ST_PROG;
              end
            end
          end
        end
        ST_PROG: begin
          if (!busy_i) st <= ST_READ;
        end
        ST_ERASE: begin
          if (suspend_i)   st <= ST_SUSP;
          else if (!busy_i) st <= ST_READ;
        end
        ST_SUSP: begin
          if (cmd_i && (op_kind_i == OP_PROGRAM)) begin
            lat_addr <= op_addr_i;
            lat_d7   <= op_d7_i;
            st       <= ST_SPROG;
          end else if (!suspend_i) begin
            st <= ST_ERASE;
          end
        end
        ST_SPROG: begin
          if (!busy_i) st <= ST_SUSP;
        end
        ST_PPROT, ST_EPROT: begin
          if (cnt == '0) st <= ST_READ;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_READ;
      endcase
    end
  end

  assign st_o       = st;
  assign lat_addr_o = lat_addr;
  assign lat_d7_o   = lat_d7;

endmodule

// File: rtl/dq7_addr_qual.sv
module dq7_addr_qual #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] lat_addr_i,
  input  logic              rd_in_sel_i,
  input  logic              rd_sec_prot_i,
  output logic              hit_prog_o,
  output logic              hit_sel_o,
  output logic              hit_erase_o
);

  always_comb begin
    hit_prog_o  = (rd_addr_i == lat_addr_i);
    hit_sel_o   = rd_in_sel_i;
    hit_erase_o = rd_in_sel_i && !rd_sec_prot_i;
  end

endmodule

// File: rtl/dq7_status_mux.sv
module dq7_status_mux
  import dq7_poll_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7
) (
  input  poll_state_e       st_i,
  input  logic              hit_prog_i,
  input  logic              hit_sel_i,
  input  logic              hit_erase_i,
  input  logic              lat_d7_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  logic use_status;
  logic status_bit;

  always_comb begin
    use_status = 1'b0;
    status_bit = 1'b0;
    unique case (st_i)
      ST_PROG, ST_PPROT: begin
        use_status = hit_prog_i;
        status_bit = !lat_d7_i;
      end
      ST_ERASE: begin
        use_status = hit_erase_i;
        status_bit = 1'b0;
      end
      ST_EPROT: begin
        use_status = hit_sel_i;
        status_bit = 1'b0;
      end
      ST_SUSP: begin
        use_status = hit_erase_i;
        status_bit = 1'b1;
      end
      ST_SPROG: begin
        if (hit_prog_i) begin
          use_status = 1'b1;
          status_bit = !lat_d7_i;
        end else begin
          use_status = hit_erase_i;
          status_bit = 1'b1;
        end
      end
      default: begin
        use_status = 1'b0;
        status_bit = 1'b0;
      end
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g == POLL_BIT) begin : g_poll
      assign data_o[g] = use_status ? status_bit : data_i[g];
    end else begin : g_pass
      assign data_o[g] = data_i[g];
    end
  end

endmodule

// File: rtl/dq7_rsp_reg.sv
module dq7_rsp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  logic         vld;
  logic [W-1:0] dat;

  assign in_ready_o = !vld || out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      dat <= '0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        vld <= 1'b1;
        dat <= in_data_i;
      end else if (out_ready_i) begin
        vld <= 1'b0;
      end
    end
  end

  assign out_valid_o = vld;
  assign out_data_o  = dat;

endmodule

// File: rtl/dq7_poll_unit.sv
module dq7_poll_unit
  import dq7_poll_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 16,
  parameter int POLL_BIT       = 7,
  parameter int CLK_MHZ        = 100,
  parameter int ERASE_ABORT_US = 100,
  parameter int PROG_ABORT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_i,
  input  logic              op_kind_i,
  input  logic              op_prot_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              op_d7_i,
  input  logic              busy_i,
  input  logic              suspend_i,
  input  logic              rd_req_valid_i,
  output logic              rd_req_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_in_sel_i,
  input  logic              rd_sec_prot_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o
);

  localparam int ERASE_ABORT_CYC = CLK_MHZ * ERASE_ABORT_US;

  poll_state_e       st;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_d7;
  logic              hit_prog;
  logic              hit_sel;
  logic              hit_erase;
  logic [DATA_W-1:0] mux_data;

  dq7_poll_seq #(
    .ADDR_W         (ADDR_W),
    .PROG_ABORT_CYC (PROG_ABORT_CYC),
    .ERASE_ABORT_CYC(ERASE_ABORT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .op_kind_i (op_kind_e'(op_kind_i)),
    .op_prot_i (op_prot_i),
    .op_addr_i (op_addr_i),
    .op_d7_i   (op_d7_i),
    .busy_i    (busy_i),
    .suspend_i (suspend_i),
    .st_o      (st),
    .lat_addr_o(lat_addr),
    .lat_d7_o  (lat_d7)
  );

  dq7_addr_qual #(
    .ADDR_W(ADDR_W)
  ) u_qual (
    .rd_addr_i    (rd_addr_i),
    .lat_addr_i   (lat_addr),
    .rd_in_sel_i  (rd_in_sel_i),
    .rd_sec_prot_i(rd_sec_prot_i),
    .hit_prog_o   (hit_prog),
    .hit_sel_o    (hit_sel),
    .hit_erase_o  (hit_erase)
  );

  dq7_status_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT)
  ) u_mux (
    .st_i       (st),
    .hit_prog_i (hit_prog),
    .hit_sel_i  (hit_sel),
    .hit_erase_i(hit_erase),
    .lat_d7_i   (lat_d7),
    .data_i     (array_data_i),
    .data_o     (mux_data)
  );

  dq7_rsp_reg #(
    .W(DATA_W)
  ) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (rd_req_valid_i),
    .in_ready_o (rd_req_ready_o),
    .in_data_i  (mux_data),
    .out_valid_o(rsp_valid_o),
    .out_ready_i(rsp_ready_i),
    .out_data_o (rsp_data_o)
  );

endmodule

// File: rtl/dq7_poll_chk.sv
module dq7_poll_chk
  import dq7_poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int POLL_BIT  = 7,
  parameter int EPROT_CYC = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input poll_state_e       st,
  input logic [ADDR_W-1:0] lat_addr,
  input logic              lat_d7,
  input logic              rd_req_valid_i,
  input logic              rd_req_ready_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_in_sel_i,
  input logic              rd_sec_prot_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o
);

  logic acc;
  assign acc = rd_req_valid_i && rd_req_ready_o;

  int unsigned eprot_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               eprot_run <= 0;
    else if (st == ST_EPROT)  eprot_run <= eprot_run + 1;
    else                      eprot_run <= 0;
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !rd_req_ready_o);

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && acc) |=> (rsp_data_o == $past(array_data_i)));

  // R2
  prog_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && acc && rd_addr_i == lat_addr) |=> (rsp_data_o[POLL_BIT] == !$past(lat_d7)));

  // R4
  erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && acc && rd_in_sel_i && !rd_sec_prot_i) |=> !rsp_data_o[POLL_BIT]);

  // R5
  susp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && acc && rd_in_sel_i && !rd_sec_prot_i) |=> rsp_data_o[POLL_BIT]);

  // R8
  eprot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EPROT) |-> (eprot_run < EPROT_CYC));

endmodule

bind dq7_poll_unit dq7_poll_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT),
  .EPROT_CYC(CLK_MHZ * ERASE_ABORT_US)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st            (st),
  .lat_addr      (lat_addr),
  .lat_d7        (lat_d7),
  .rd_req_valid_i(rd_req_valid_i),
  .rd_req_ready_o(rd_req_ready_o),
  .rd_addr_i     (rd_addr_i),
  .rd_in_sel_i   (rd_in_sel_i),
  .rd_sec_prot_i (rd_sec_prot_i),
  .array_data_i  (array_data_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_data_o    (rsp_data_o)
);

// File: tb/dq7_poll_unit_tb.sv
`timescale 1ns/1ps
module dq7_poll_unit_tb;

  localparam int AW    = 24;
  localparam int DW    = 16;
  localparam int PCYC  = 16;
  localparam int LIMIT = 100 * 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_i = 1'b0;
  logic          op_kind_i = 1'b0;
  logic          op_prot_i = 1'b0;
  logic [AW-1:0] op_addr_i = '0;
  logic          op_d7_i = 1'b0;
  logic          busy_i = 1'b0;
  logic          suspend_i = 1'b0;
  logic          rd_req_valid_i = 1'b0;
  logic          rd_req_ready_o;
  logic [AW-1:0] rd_addr_i = '0;
  logic          rd_in_sel_i = 1'b0;
  logic          rd_sec_prot_i = 1'b0;
  logic [DW-1:0] array_data_i = '0;
  logic          rsp_valid_o;
  logic          rsp_ready_i = 1'b1;
  logic [DW-1:0] rsp_data_o;

  always #5 clk = ~clk;

  dq7_poll_unit #(
    .ADDR_W(AW), .DATA_W(DW), .POLL_BIT(7),
    .CLK_MHZ(100), .ERASE_ABORT_US(100), .PROG_ABORT_CYC(PCYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .op_kind_i(op_kind_i),
    .op_prot_i(op_prot_i), .op_addr_i(op_addr_i), .op_d7_i(op_d7_i),
    .busy_i(busy_i), .suspend_i(suspend_i),
    .rd_req_valid_i(rd_req_valid_i), .rd_req_ready_o(rd_req_ready_o),
    .rd_addr_i(rd_addr_i), .rd_in_sel_i(rd_in_sel_i), .rd_sec_prot_i(rd_sec_prot_i),
    .array_data_i(array_data_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per handed-over response
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid_o && rsp_ready_i) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_data_o);
      end else begin
        check(tag_q.pop_front(), rsp_data_o, exp_q.pop_front());
      end
    end
  end

  // driver: starts and returns at a falling edge
  task automatic rd(input logic [AW-1:0] a, input logic sel, input logic prot,
                    input logic [DW-1:0] arr, input logic [DW-1:0] exp, input string tag);
    bit acc;
    rd_req_valid_i = 1'b1;
    rd_addr_i      = a;
    rd_in_sel_i    = sel;
    rd_sec_prot_i  = prot;
    array_data_i   = arr;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    forever begin
      #1;
      acc = rd_req_ready_o;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    rd_req_valid_i = 1'b0;
  endtask

  task automatic cmd(input logic kind, input logic prot, input logic [AW-1:0] a,
                     input logic d7, input logic bsy);
    cmd_i     = 1'b1;
    op_kind_i = kind;
    op_prot_i = prot;
    op_addr_i = a;
    op_d7_i   = d7;
    busy_i    = bsy;
    @(posedge clk);
    @(negedge clk);
    cmd_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    check("R10 reset rsp_valid", {15'd0, rsp_valid_o}, 16'd0);
    check("R10 reset req_ready", {15'd0, rd_req_ready_o}, 16'd1);
    @(negedge clk);

    // R1 read mode pass-through
    rd(24'h000010, 1'b1, 1'b0, 16'h5AD5, 16'h5AD5, "R1 idle passthrough");

    // R11 read on the command edge sees read mode; R2 program d7=1
    fork
      cmd(1'b0, 1'b0, 24'h000100, 1'b1, 1'b1);
      rd(24'h000100, 1'b0, 1'b0, 16'h00FF, 16'h00FF, "R11 same-edge read");
    join
    rd(24'h000100, 1'b0, 1'b0, 16'h00FF, 16'h007F, "R2 program addr inverse d7=1");
    rd(24'h000104, 1'b0, 1'b0, 16'h00FF, 16'h00FF, "R2 other addr passthrough");
    // R9 erase command ignored during program
    cmd(1'b1, 1'b0, 24'h000200, 1'b0, 1'b1);
    rd(24'h000100, 1'b0, 1'b0, 16'h3CFF, 16'h3C7F, "R9 program status kept");
    rd(24'h000300, 1'b1, 1'b0, 16'h00FF, 16'h00FF, "R9 no erase status");
    busy_i = 1'b0;
    @(negedge clk);
    rd(24'h000100, 1'b0, 1'b0, 16'h00A5, 16'h00A5, "R3 program done true data");

    // R2 program d7=0
    cmd(1'b0, 1'b0, 24'h000180, 1'b0, 1'b1);
    rd(24'h000180, 1'b0, 1'b0, 16'h0000, 16'h0080, "R2 program addr inverse d7=0");
    busy_i = 1'b0;
    @(negedge clk);
    rd(24'h000180, 1'b0, 1'b0, 16'h0000, 16'h0000, "R3 program done d7=0");

    // R4 erase
    cmd(1'b1, 1'b0, 24'h000000, 1'b0, 1'b1);
    rd(24'h001000, 1'b1, 1'b0, 16'h12B4, 16'h1234, "R4 erase selected zero");
    rd(24'h002000, 1'b1, 1'b1, 16'h12B4, 16'h12B4, "R4 erase protected passthrough");
    rd(24'h003000, 1'b0, 1'b0, 16'h12B4, 16'h12B4, "R4 erase unselected passthrough");
    // R5 suspend
    suspend_i = 1'b1;
    @(negedge clk);
    rd(24'h001000, 1'b1, 1'b0, 16'h1234, 16'h12B4, "R5 suspended reads one");
    // R6 program in suspend
    cmd(1'b0, 1'b0, 24'h004000, 1'b1, 1'b1);
    rd(24'h004000, 1'b0, 1'b0, 16'h00FF, 16'h007F, "R6 suspend program inverse");
    rd(24'h001004, 1'b1, 1'b0, 16'h0000, 16'h0080, "R6 suspend other erase addr one");
    busy_i = 1'b0;
    @(negedge clk);
    rd(24'h001008, 1'b1, 1'b0, 16'h0000, 16'h0080, "R6 back to suspend");
    // R5 resume
    suspend_i = 1'b0;
    busy_i    = 1'b1;
    @(negedge clk);
    rd(24'h001000, 1'b1, 1'b0, 16'h00FF, 16'h007F, "R5 resumed erase zero");
    busy_i = 1'b0;
    @(negedge clk);
    rd(24'h001000, 1'b1, 1'b0, 16'h00FF, 16'h00FF, "R3 erase done passthrough");

    // R7 protected program
    cmd(1'b0, 1'b1, 24'h005000, 1'b1, 1'b0);
    rd(24'h005000, 1'b0, 1'b1, 16'h00FF, 16'h007F, "R7 protected program brief status");
    repeat (PCYC + 2) @(negedge clk);
    rd(24'h005000, 1'b0, 1'b1, 16'h00FF, 16'h00FF, "R7 protected program back to read");

    // R8 protected erase window, exact boundaries
    cmd(1'b1, 1'b1, 24'h000000, 1'b0, 1'b0);
    repeat (LIMIT - 1) @(negedge clk);
    rd(24'h006000, 1'b1, 1'b1, 16'h00FF, 16'h007F, "R8 last window cycle zero");
    rd(24'h006000, 1'b1, 1'b1, 16'h00FF, 16'h00FF, "R8 after window read mode");
    drain();

    // R10 back-pressure
    rsp_ready_i = 1'b0;
    rd(24'h000020, 1'b0, 1'b0, 16'h1111, 16'h1111, "R10 stalled first");
    #1;
    held = rsp_data_o;
    fork
      rd(24'h000024, 1'b0, 1'b0, 16'h2222, 16'h2222, "R10 second after stall");
      begin
        @(negedge clk);
        #1;
        check("R10 held data", rsp_data_o, held);
        check("R10 held valid", {15'd0, rsp_valid_o}, 16'd1);
        check("R10 blocked request", {15'd0, rd_req_ready_o}, 16'd0);
        @(negedge clk);
        rsp_ready_i = 1'b1;
      end
    join
    drain();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule